// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 peripheral interrupt lines and turns them into four parent interrupt outputs and four per-core outputs. Each source line first passes through a two-flop synchroniser. Each source then has its own trigger mode: high level, low level, rising edge or falling edge. Its pending state is qualified by an enable bit. A byte-wide route entry per source then steers it onto any set of parent lines and any set of cores. The parent and core outputs are the registered OR of every enabled, pending source routed to them.

Software reaches the block through a single-cycle register port that takes full-word or byte-lane writes. Enables change through separate set and clear strobes, so no read-modify-write is needed. A status word reports which enabled sources are pending, so a handler that sees a parent line asserted always finds a cause. Software brings the block up by clearing all enables and then zeroing the edge word. After that sequence every source works as a level input.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable word (0x24) and the edge word (0x34) read 0, the polarity word (0x30) reads 0xFFFFFFFF, every route byte reads 0, and all parent and core outputs are 0.
- R2: The route entry of source n is the byte at offset n (0x00–0x1F). Bit 4+k routes it to parent line k, and bit c (c in 0..3) routes it to core c. A write changes only the byte lanes whose byte-enable bit is 1.
- R3: A write to 0x28 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 stay as they were, and enables change only on writes.
- R4: A write to 0x2C clears each enable bit whose data bit is 1, and also drops any latched edge event of that source. The sequence of writing all ones to 0x2C and then 0 to 0x34 leaves every source disabled and level-triggered.
- R5: The current enable vector reads back at offset 0x24. The set (0x28) and clear (0x2C) locations read 0.
- R6: With edge bit 0, a source is asserted while its synchronised input equals its polarity bit (polarity 1 gives high level, polarity 0 gives low level). It follows the input and is not latched.
- R7: With edge bit 1, a source latches an event on a rising input (polarity 1) or on a falling input (polarity 0). The event stays latched after the input returns, until the source is cleared through 0x2C.
- R8: The word at 0x40 has bit n set exactly when source n is asserted and enabled.
- R9: Parent output k is the registered OR of the pending sources whose route bit 4+k is set, and core output c is the same for route bit c. A level input change reaches the outputs on the third rising clock edge.
- R10: Read data and a read-valid flag appear one cycle after a read strobe. Offsets that are unmapped or not word aligned read 0 and ignore writes.
- R11: A source that is disabled, or whose route byte is 0, never asserts any parent or core output.
- R12: Whenever a parent output is high, the pending word was nonzero in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Raw peripheral interrupt lines, asynchronous |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_be_i | input | 4 | Byte-lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| bus_rdata_o | output | 32 | Read data |
| parent_irq_o | output | 4 | Parent interrupt lines |
| core_irq_o | output | 4 | Per-core interrupt lines |

## Verification
The enable properties assume that the bus holds one access per strobe. They also assume that set and clear words are written with all four byte lanes enabled whenever the checker relates the data to the resulting enable vector. The stimulus writes those words only as full words, and it raises the strobe for exactly one cycle per access, between falling edges. The interrupt inputs are changed only on falling clock edges and held for at least a cycle. This keeps every edge event visible to the synchroniser, so the behavioural model in the bench and the design see the same transitions.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_BE = BUS_DW / 8;

  // word indices (byte offset >> 2) of the control words
  localparam logic [5:0] WIX_EN_RD  = 6'h09;
  localparam logic [5:0] WIX_EN_SET = 6'h0A;
  localparam logic [5:0] WIX_EN_CLR = 6'h0B;
  localparam logic [5:0] WIX_POL    = 6'h0C;
  localparam logic [5:0] WIX_EDGE   = 6'h0D;
  localparam logic [5:0] WIX_PEND   = 6'h10;

  function automatic logic [BUS_DW-1:0] lane_mask(input logic [BUS_BE-1:0] be);
    logic [BUS_DW-1:0] m;
    for (int b = 0; b < BUS_BE; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/irc_trigger.sv
module irc_trigger #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] drop_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] held_q;
  logic [N-1:0] held_d;
  logic [N-1:0] hit;

  always_comb begin
    for (int n = 0; n < N; n++) begin
      hit[n] = pol_i[n] ? (lvl_i[n] & ~prev_q[n]) : (~lvl_i[n] & prev_q[n]);
      if (!edge_i[n] || drop_i[n]) held_d[n] = 1'b0;
      else                         held_d[n] = held_q[n] | hit[n];
      act_o[n] = edge_i[n] ? held_q[n] : ~(lvl_i[n] ^ pol_i[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held_q <= '0;
    end else begin
      prev_q <= lvl_i;
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned RW   = 8,
  localparam int unsigned RTW = NSRC * RW,
  localparam int unsigned NRW = RTW / BUS_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_BE-1:0] be_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [RTW-1:0]    route_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   pol_o,
  output logic [NSRC-1:0]   edge_o,
  output logic [NSRC-1:0]   drop_o,
  output logic              rvalid_o,
  output logic [BUS_DW-1:0] rdata_o
);
  logic [RTW-1:0]    route_q, route_d;
  logic [NSRC-1:0]   en_q, en_d;
  logic [NSRC-1:0]   pol_q, pol_d;
  logic [NSRC-1:0]   edge_q, edge_d;
  logic              rvalid_q;
  logic [BUS_DW-1:0] rdata_q, rdata_d;
  logic              aligned, wr, rd, cfg_ce;
  logic [5:0]        wix;
  logic [BUS_DW-1:0] bm, wm;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wix     = addr_i[BUS_AW-1:2];
  assign wr      = sel_i & we_i & aligned;
  assign rd      = sel_i & ~we_i;
  assign cfg_ce  = wr;
  assign bm      = lane_mask(be_i);
  assign wm      = wdata_i & bm;

  always_comb begin
    route_d = route_q;
    en_d    = en_q;
    pol_d   = pol_q;
    edge_d  = edge_q;
    drop_o  = '0;
    if (wr) begin
      for (int w = 0; w < NRW; w++)
        if (wix == 6'(w))
          route_d[BUS_DW*w +: BUS_DW] = (route_q[BUS_DW*w +: BUS_DW] & ~bm) | wm;
      unique case (wix)
        WIX_EN_SET: en_d   = en_q | wm[NSRC-1:0];
        WIX_EN_CLR: begin
          en_d   = en_q & ~wm[NSRC-1:0];
          drop_o = wm[NSRC-1:0];
        end
        WIX_POL:    pol_d  = (pol_q & ~bm[NSRC-1:0]) | wm[NSRC-1:0];
        WIX_EDGE:   edge_d = (edge_q & ~bm[NSRC-1:0]) | wm[NSRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd && aligned) begin
      for (int w = 0; w < NRW; w++)
        if (wix == 6'(w)) rdata_d = route_q[BUS_DW*w +: BUS_DW];
      unique case (wix)
        WIX_EN_RD: rdata_d[NSRC-1:0] = en_q;
        WIX_POL:   rdata_d[NSRC-1:0] = pol_q;
        WIX_EDGE:  rdata_d[NSRC-1:0] = edge_q;
        WIX_PEND:  rdata_d[NSRC-1:0] = pend_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      pol_q   <= '1;
      edge_q  <= '0;
    end else if (cfg_ce) begin
      route_q <= route_d;
      en_q    <= en_d;
      pol_q   <= pol_d;
      edge_q  <= edge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      rdata_q  <= rdata_d;
    end
  end

  assign route_o  = route_q;
  assign en_o     = en_q;
  assign pol_o    = pol_q;
  assign edge_o   = edge_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/irc_fanout.sv
module irc_fanout #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NPAR  = 4,
  parameter int unsigned NCORE = 4,
  localparam int unsigned RW   = NPAR + NCORE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC*RW-1:0] route_i,
  output logic [NPAR-1:0]    par_o,
  output logic [NCORE-1:0]   core_o
);
  logic [NPAR-1:0]  par_d, par_q;
  logic [NCORE-1:0] core_d, core_q;

  for (genvar k = 0; k < NPAR; k++) begin : g_par
    logic [NSRC-1:0] hits;
    always_comb
      for (int n = 0; n < NSRC; n++) hits[n] = pend_i[n] & route_i[RW*n + NCORE + k];
    assign par_d[k] = |hits;
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NSRC-1:0] hits;
    always_comb
      for (int n = 0; n < NSRC; n++) hits[n] = pend_i[n] & route_i[RW*n + c];
    assign core_d[c] = |hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= '0;
      core_q <= '0;
    end else begin
      par_q  <= par_d;
      core_q <= core_d;
    end
  end

  assign par_o  = par_q;
  assign core_o = core_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NPAR  = 4,
  parameter int unsigned NCORE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_BE-1:0] bus_be_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic [NPAR-1:0]   parent_irq_o,
  output logic [NCORE-1:0]  core_irq_o
);
  localparam int unsigned RW = NPAR + NCORE;

  logic [NSRC-1:0]    lvl_vec, act_vec, pend_vec;
  logic [NSRC-1:0]    en_vec, pol_vec, edge_vec, drop_vec;
  logic [NSRC*RW-1:0] route_vec;

  irc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_src_i), .q_o(lvl_vec)
  );

  irc_trigger #(.N(NSRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_vec), .pol_i(pol_vec),
    .edge_i(edge_vec), .drop_i(drop_vec), .act_o(act_vec)
  );

  assign pend_vec = act_vec & en_vec;

  irc_regs #(.NSRC(NSRC), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .be_i(bus_be_i), .wdata_i(bus_wdata_i),
    .pend_i(pend_vec), .route_o(route_vec), .en_o(en_vec), .pol_o(pol_vec),
    .edge_o(edge_vec), .drop_o(drop_vec), .rvalid_o(bus_rvalid_o),
    .rdata_o(bus_rdata_o)
  );

  irc_fanout #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_fan (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_vec), .route_i(route_vec),
    .par_o(parent_irq_o), .core_o(core_irq_o)
  );
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int unsigned N     = 32,
  parameter int unsigned NPAR  = 4,
  parameter int unsigned NCORE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [7:0]       bus_addr_i,
  input logic [3:0]       bus_be_i,
  input logic [31:0]      bus_wdata_i,
  input logic             bus_rvalid_o,
  input logic [N-1:0]     en_vec,
  input logic [N-1:0]     pend_vec,
  input logic [NPAR-1:0]  parent_irq_o,
  input logic [NCORE-1:0] core_irq_o
);
  logic rd_req, set_full, clr_full;
  assign rd_req   = bus_sel_i & ~bus_we_i;
  assign set_full = bus_sel_i & bus_we_i & (bus_addr_i == 8'h28) & (bus_be_i == 4'hF);
  assign clr_full = bus_sel_i & bus_we_i & (bus_addr_i == 8'h2C) & (bus_be_i == 4'hF);

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid_o);
  p_rquiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid_o);
  p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_full |=> ((en_vec & $past(bus_wdata_i[N-1:0])) == $past(bus_wdata_i[N-1:0])));
  p_enhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel_i && bus_we_i) |=> $stable(en_vec));
  p_enclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_full |=> ((en_vec & $past(bus_wdata_i[N-1:0])) == '0));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |=> (parent_irq_o == '0 && core_irq_o == '0));
  p_nospur_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (parent_irq_o != '0) |-> ($past(pend_vec) != '0));
endmodule

bind irq_route_ctrl irc_checker #(.N(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_be_i(bus_be_i), .bus_wdata_i(bus_wdata_i),
  .bus_rvalid_o(bus_rvalid_o), .en_vec(en_vec), .pend_vec(pend_vec),
  .parent_irq_o(parent_irq_o), .core_irq_o(core_irq_o)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  logic [3:0]  par, core;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rvalid_o(rvalid), .bus_rdata_o(rdata), .parent_irq_o(par), .core_irq_o(core)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_en, m_pol, m_edge, m_lat, m_s, m_sp;
  logic [7:0]  m_route [32];
  logic [31:0] m_hist [$];
  logic [3:0]  m_par, m_core;
  logic        m_rv;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_pending();
    logic [31:0] p;
    for (int n = 0; n < 32; n++) begin
      logic a;
      if (m_edge[n]) a = m_lat[n];
      else           a = m_pol[n] ? m_s[n] : !m_s[n];
      p[n] = a && m_en[n];
    end
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v = '0;
    if (a[1:0] != 2'b00) return '0;
    if (a < 8'h20) begin
      for (int b = 0; b < 4; b++) v[8*b +: 8] = m_route[a + b];
    end else if (a == 8'h24) v = m_en;
    else if (a == 8'h30) v = m_pol;
    else if (a == 8'h34) v = m_edge;
    else if (a == 8'h40) v = m_pending();
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_pol = '1; m_edge = '0; m_lat = '0; m_s = '0; m_sp = '0;
      for (int n = 0; n < 32; n++) m_route[n] = '0;
      m_hist = {32'h0};
      m_par = '0; m_core = '0; m_rv = 1'b0; m_rd = '0;
    end else begin
      logic [31:0] p, bmask, clr;
      logic        wr_ok;
      p = m_pending();
      m_par = '0; m_core = '0;
      for (int n = 0; n < 32; n++)
        if (p[n]) begin
          m_par  = m_par  | m_route[n][7:4];
          m_core = m_core | m_route[n][3:0];
        end
      m_rv = sel && !we;
      m_rd = (sel && !we) ? m_read(addr) : '0;
      for (int b = 0; b < 4; b++) bmask[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
      wr_ok = sel && we && (addr[1:0] == 2'b00);
      clr = (wr_ok && addr == 8'h2C) ? (wdata & bmask) : '0;
      for (int n = 0; n < 32; n++) begin
        if (!m_edge[n] || clr[n]) m_lat[n] = 1'b0;
        else if (m_pol[n] ? (m_s[n] && !m_sp[n]) : (!m_s[n] && m_sp[n])) m_lat[n] = 1'b1;
      end
      if (wr_ok) begin
        if (addr < 8'h20) begin
          for (int b = 0; b < 4; b++) if (be[b]) m_route[addr + b] = wdata[8*b +: 8];
        end
        else if (addr == 8'h28) m_en = m_en | (wdata & bmask);
        else if (addr == 8'h2C) m_en = m_en & ~(wdata & bmask);
        else if (addr == 8'h30) m_pol = (m_pol & ~bmask) | (wdata & bmask);
        else if (addr == 8'h34) m_edge = (m_edge & ~bmask) | (wdata & bmask);
      end
      m_sp = m_s;
      m_s = m_hist.pop_front();
      m_hist.push_back(src);
    end
  end

  // per-clock comparison against the model (R9 outputs, R10 read port)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (par !== m_par) begin bad++; $display("FAIL R9 parent got=%h exp=%h t=%0t", par, m_par, $time); end
      total++;
      if (core !== m_core) begin bad++; $display("FAIL R9 core got=%h exp=%h t=%0t", core, m_core, $time); end
      total++;
      if (rvalid !== m_rv || (m_rv && rdata !== m_rd)) begin
        bad++; $display("FAIL R10 read got=%b/%h exp=%b/%h t=%0t", rvalid, rdata, m_rv, m_rd, $time);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 outputs", {24'h0, par, core}, 32'h0);
    rd(8'h24, v); chk("R1 enable", v, 32'h0);
    rd(8'h30, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R1 edge", v, 32'h0);
    rd(8'h00, v); chk("R1 route", v, 32'h0);
    // R2 route bytes with lane writes
    wr(8'h00, 4'b0010, 32'hAAAA_21BB);
    wr(8'h00, 4'b0100, 32'hCC42_DDEE);
    rd(8'h00, v); chk("R2 route lanes", v, 32'h0042_2100);
    // R3 / R5 enable set and readback
    wr(8'h28, 4'hF, 32'h6);
    wr(8'h28, 4'hF, 32'h1);
    rd(8'h24, v); chk("R3 R5 enable set", v, 32'h7);
    rd(8'h28, v); chk("R5 set word reads zero", v, 32'h0);
    // R4 clear
    wr(8'h2C, 4'hF, 32'h1);
    rd(8'h24, v); chk("R4 enable clear", v, 32'h6);
    // R9 latency and R6 high level
    @(negedge clk); src[1] = 1'b1;
    cyc(2); chk("R9 not yet", {28'h0, par}, 32'h0);
    cyc(1); chk("R9 parent1", {28'h0, par}, 32'h2);
    chk("R9 core0", {28'h0, core}, 32'h1);
    rd(8'h40, v); chk("R8 pending", v, 32'h2);
    src[1] = 1'b0; cyc(4);
    chk("R6 level follows input", {28'h0, par}, 32'h0);
    // R6 low level
    wr(8'h30, 4'hF, 32'hFFFF_FFFD); cyc(3);
    chk("R6 low level active", {28'h0, par}, 32'h2);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF); cyc(3);
    chk("R6 low level off", {28'h0, par}, 32'h0);
    // R11 unrouted and R8 disabled source
    src[5] = 1'b1; src[3] = 1'b1;
    wr(8'h28, 4'hF, 32'h20); cyc(4);
    chk("R11 unrouted parent", {28'h0, par}, 32'h0);
    chk("R11 unrouted core", {28'h0, core}, 32'h0);
    rd(8'h40, v); chk("R8 disabled excluded", v, 32'h20);
    wr(8'h2C, 4'hF, 32'h20);
    // R7 rising edge latch
    wr(8'h34, 4'hF, 32'h4);
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); src[2] = 1'b0;
    cyc(6);
    chk("R7 rising latched parent", {28'h0, par}, 32'h4);
    chk("R7 rising latched core", {28'h0, core}, 32'h2);
    rd(8'h40, v); chk("R7 R8 pending latched", v, 32'h4);
    wr(8'h2C, 4'hF, 32'h4); cyc(2);
    chk("R4 clear drops latch", {28'h0, par}, 32'h0);
    rd(8'h24, v); chk("R4 enable after clear", v, 32'h2);
    wr(8'h28, 4'hF, 32'h4); cyc(3);
    chk("R4 latch stays dropped", {28'h0, par}, 32'h0);
    // R7 falling edge
    wr(8'h30, 4'hF, 32'hFFFF_FFFB);
    @(negedge clk); src[2] = 1'b1; cyc(5);
    chk("R7 falling ignores rise", {28'h0, par}, 32'h0);
    src[2] = 1'b0; cyc(5);
    chk("R7 falling latched", {28'h0, par}, 32'h4);
    // R4 bring-up sequence
    wr(8'h2C, 4'hF, 32'hFFFF_FFFF);
    wr(8'h34, 4'hF, 32'h0);
    rd(8'h24, v); chk("R4 init enables", v, 32'h0);
    rd(8'h40, v); chk("R4 init pending", v, 32'h0);
    wr(8'h28, 4'hF, 32'h4); cyc(3);
    chk("R4 level after init", {28'h0, par}, 32'h4);
    // R10 unmapped and misaligned
    rd(8'h20, v); chk("R10 unmapped read", v, 32'h0);
    wr(8'h20, 4'hF, 32'hFFFF_FFFF);
    wr(8'h31, 4'hF, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R10 misaligned write ignored", v, 32'hFFFF_FFFB);
    rd(8'h24, v); chk("R10 enable untouched", v, 32'h4);
    rd(8'h2C, v); chk("R5 clear word reads zero", v, 32'h0);
    cyc(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule